// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns parallel characters into an asynchronous serial stream on a single output line. Each frame is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then a stop interval during which the line is high. The stop interval can be set in half-bit steps from zero to three bit times. All bit timing comes from a 16x oversampling enable, `tick`, supplied by an external divider. A full bit lasts 16 ticks and a half bit lasts 8.

Characters enter through a valid/ready handshake into a one-entry holding register. The holding register feeds the shift register, so the next character can wait while the current one is being sent. The `tx_empty` flag shows when the holding register can take another character. The format settings (length, parity and stop interval) are captured when a character moves into the shift register, so they stay fixed for the whole frame. A break input pulls the line low for as long as it is held and abandons any frame in flight. When break is released, the line is held high for one full bit time before the next start bit.

The state machine has seven states:

- **IDLE**: the line is high.
  - IDLE→START when the holding register is full. This move is the *take*.
- **START**: the line is low.
  - START→DATA after 16 ticks.
- **DATA**: the current data bit is on the line.
  - DATA stays in DATA for each bit except the last.
  - After the last bit, DATA→PARITY if parity is on. Otherwise it leaves as described in the next line.
  - DATA or PARITY→STOP when the stop interval is not zero.
  - DATA or PARITY→START (a chained take) when the stop interval is zero and a character is waiting.
  - DATA or PARITY→IDLE when the stop interval is zero and no character is waiting.
- **PARITY**: the parity bit is on the line.
- **STOP**: the line is high.
  - STOP→IDLE when the stop interval ends.
- **BREAK**: the line is low.
  - Any state→BREAK whenever `brk` is high.
  - BREAK→RECOVER when `brk` falls.
- **RECOVER**: the line is high.
  - RECOVER→IDLE after 16 ticks.

Top module: `sertx_top`

## Requirements
- R1: After reset, and whenever no frame or break is active, `txd` is 1, and `in_ready` and `tx_empty` are both 1.
- R2: A frame starts with `txd` low for 16 ticks. It is followed by 5, 6, 7 or 8 data bits, selected by `cfg_len` = 0, 1, 2 or 3. Each data bit lasts 16 ticks, and bit 0 is sent first.
- R3: When `cfg_par_en` is 1, one parity bit of 16 ticks follows the data. With `cfg_par_odd` = 0 it is the XOR of the active data bits (even parity). With `cfg_par_odd` = 1 it is the inverse of that XOR (odd parity). Data bits above the selected length have no effect on the line.
- R4: After the data and parity bits, `txd` stays high for a stop interval set by `cfg_stop`:
  - codes 0, 1, 2, 3 and 4 give 0, 16, 24, 32 and 40 ticks;
  - codes 5, 6 and 7 give 48 ticks.
- R5: With a stop interval of zero, when a character is waiting, its start bit begins right after the last data or parity bit.
- R6: A character is accepted on a clock where `in_valid` and `in_ready` are both 1. The next clock `in_ready` is 0, and it stays 0 until the character moves into the shift register. One character can be accepted while another is being sent.
- R7: `tx_empty` goes to 0 on the clock after a character is accepted. It returns to 1 on the clock where that character moves into the shift register, which is the same clock in which the start bit of that character goes onto `txd`.
- R8: One clock after `brk` is 1, `txd` is 0, and it stays 0 while `brk` stays 1. A character waiting in the holding register is kept and is not sent during break.
- R9: One clock after `brk` falls, `txd` is 1. It stays 1 for 16 ticks before any start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | 16x oversampling enable, one clock wide |
| cfg_len | input | 2 | Data length code: 0..3 selects 5..8 bits |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| cfg_stop | input | 3 | Stop interval code in half-bit steps |
| brk | input | 1 | Hold the line in break (low) |
| in_valid | input | 1 | A character is offered on `in_data` |
| in_data | input | 8 | Character to send |
| in_ready | output | 1 | The holding register is free |
| txd | output | 1 | Serial output line |
| tx_empty | output | 1 | Transmit-empty flag |

## Verification
Results appear at two different delays.

- **One clock after a stimulus.** An accepted character shows on `in_ready` and `tx_empty` one clock after the accepting edge. A change on `brk` shows on `txd` one clock later. The bench samples all of these at the falling edge that follows the edge in question.
- **Counted in ticks.** Every serial position is measured from a base. The base is the tick count at the first falling clock edge where the start bit is visible. Bit k occupies ticks base+16k+1 to base+16k+16. The bench samples bit k at tick base+16k+8, which is the middle of the bit. The stop interval is checked one tick before it ends, and the start of the following character at its own expected position, so an interval that is too short or too long fails.
- **Tick spacing.** The bench issues a tick every third clock. This leaves the one-clock pass through IDLE between frames free of ticks, so the expected frame length in ticks is exact.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_BREAK,
        ST_RECOVER
    } sertx_state_t;

    // Stop interval in half-bit units for a given stop code; codes above 5 saturate at three bits.
    function automatic logic [2:0] stop_halves(input logic [2:0] code);
        if (code == 3'd0) begin
            return 3'd0;
        end else if (code >= 3'd5) begin
            return 3'd6;
        end else begin
            return code + 3'd1;
        end
    endfunction

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    input  logic          take,
    output logic          in_ready,
    output logic          hold_full,
    output logic [DW-1:0] hold_data,
    output logic          tx_empty
);

    logic full_q;
    logic empty_q;
    logic [DW-1:0] data_q;
    logic load;

    assign load = in_valid && !full_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_q  <= 1'b0;
            empty_q <= 1'b1;
            data_q  <= '0;
        end else if (load) begin
            full_q  <= 1'b1;
            empty_q <= 1'b0;
            data_q  <= in_data;
        end else if (take) begin
            full_q  <= 1'b0;
            empty_q <= 1'b1;
        end
    end

    assign in_ready  = !full_q;
    assign hold_full = full_q;
    assign hold_data = data_q;
    assign tx_empty  = empty_q;

endmodule

// File: rtl/sertx_fsm.sv
module sertx_fsm
    import sertx_pkg::*;
#(
    parameter int DW  = 8,
    parameter int TPB = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          brk,
    input  logic [1:0]    cfg_len,
    input  logic          cfg_par_en,
    input  logic          cfg_par_odd,
    input  logic [2:0]    cfg_stop,
    input  logic          hold_full,
    input  logic [DW-1:0] hold_data,
    output logic          take,
    output logic          txd
);

    localparam int HALF = TPB / 2;
    localparam int CW   = $clog2(3 * TPB + 1);
    localparam int IW   = $clog2(DW);
    localparam int MINB = DW - 3;

    sertx_state_t state, nxt;

    logic [CW-1:0] cnt;
    logic [CW-1:0] stop_q;
    logic [CW-1:0] stop_calc;
    logic [IW-1:0] bit_idx;
    logic [IW-1:0] last_q;
    logic [DW-1:0] shreg;
    logic          par_q;
    logic          pe_q;
    logic          par_calc;
    logic          bit_done;
    logic          stop_done;
    logic          counting;

    assign stop_calc = CW'(stop_halves(cfg_stop)) * CW'(HALF);
    assign bit_done  = tick && (cnt == CW'(TPB - 1));
    assign stop_done = tick && (cnt == stop_q - CW'(1));
    assign counting  = (state != ST_IDLE) && (state != ST_BREAK);

    always_comb begin
        par_calc = cfg_par_odd;
        for (int i = 0; i < DW; i++) begin
            if (i < MINB + int'(cfg_len)) begin
                par_calc = par_calc ^ hold_data[i];
            end
        end
    end

    // Next state and take decision
    always_comb begin
        nxt  = state;
        take = 1'b0;
        if (brk) begin
            nxt = ST_BREAK;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (hold_full) begin
                        nxt  = ST_START;
                        take = 1'b1;
                    end
                end
                ST_START: begin
                    if (bit_done) nxt = ST_DATA;
                end
                ST_DATA, ST_PARITY: begin
                    if (bit_done && (state == ST_PARITY || bit_idx == last_q)) begin
                        if (state == ST_DATA && pe_q) begin
                            nxt = ST_PARITY;
                        end else if (stop_q != '0) begin
                            nxt = ST_STOP;
                        end else if (hold_full) begin
                            nxt  = ST_START;
                            take = 1'b1;
                        end else begin
                            nxt = ST_IDLE;
                        end
                    end
                end
                ST_STOP: begin
                    if (stop_done) nxt = ST_IDLE;
                end
                ST_BREAK: begin
                    nxt = ST_RECOVER;
                end
                ST_RECOVER: begin
                    if (bit_done) nxt = ST_IDLE;
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Frame datapath: settings captured on take, shifter, tick counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            stop_q  <= '0;
            bit_idx <= '0;
            last_q  <= '0;
            shreg   <= '0;
            par_q   <= 1'b0;
            pe_q    <= 1'b0;
        end else begin
            if (take) begin
                shreg   <= hold_data;
                bit_idx <= '0;
                last_q  <= IW'(MINB - 1) + IW'(cfg_len);
                pe_q    <= cfg_par_en;
                par_q   <= par_calc;
                stop_q  <= stop_calc;
            end else if (state == ST_DATA && bit_done) begin
                shreg   <= shreg >> 1;
                bit_idx <= bit_idx + IW'(1);
            end
            if (take || (nxt != state) || (state == ST_DATA && bit_done) || !counting) begin
                cnt <= '0;
            end else if (tick) begin
                cnt <= cnt + CW'(1);
            end
        end
    end

    // Line level per state
    always_comb begin
        unique case (state)
            ST_START, ST_BREAK: txd = 1'b0;
            ST_DATA:            txd = shreg[0];
            ST_PARITY:          txd = par_q;
            default:            txd = 1'b1;
        endcase
    end

endmodule

// File: rtl/sertx_top.sv
module sertx_top #(
    parameter int DW  = 8,
    parameter int TPB = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [1:0]    cfg_len,
    input  logic          cfg_par_en,
    input  logic          cfg_par_odd,
    input  logic [2:0]    cfg_stop,
    input  logic          brk,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          in_ready,
    output logic          txd,
    output logic          tx_empty
);

    logic          take;
    logic          hold_full;
    logic [DW-1:0] hold_data;

    sertx_hold #(.DW(DW)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .take      (take),
        .in_ready  (in_ready),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .tx_empty  (tx_empty)
    );

    sertx_fsm #(.DW(DW), .TPB(TPB)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .brk         (brk),
        .cfg_len     (cfg_len),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_odd (cfg_par_odd),
        .cfg_stop    (cfg_stop),
        .hold_full   (hold_full),
        .hold_data   (hold_data),
        .take        (take),
        .txd         (txd)
    );

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
    input logic clk,
    input logic rst_n,
    input logic brk,
    input logic in_valid,
    input logic in_ready,
    input logic tx_empty,
    input logic txd
);

    p_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    p_empty_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !tx_empty);

    p_empty_on_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_empty) |-> !txd);

    p_break_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        brk |=> !txd);

    p_release_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(brk) |=> txd);

endmodule

bind sertx_top sertx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .brk      (brk),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .tx_empty (tx_empty),
    .txd      (txd)
);

// File: tb/sim_sertx_top.sv
`timescale 1ns/1ps
module sim_sertx_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic [2:0] cfg_stop = 3'd1;
    logic       brk = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic       txd;
    logic       tx_empty;

    int checks = 0;
    int errors = 0;
    int tdiv = 0;
    int tcount = 0;

    always #5 clk = ~clk;

    always @(negedge clk) tdiv <= (tdiv == 2) ? 0 : tdiv + 1;
    assign tick = (tdiv == 0);
    always @(posedge clk) if (tick) tcount <= tcount + 1;

    sertx_top u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_len(cfg_len),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_stop(cfg_stop),
        .brk(brk), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .txd(txd), .tx_empty(tx_empty)
    );

    // {len[23:22], par_en[21], odd[20], stop[19:17], pad[16], first[15:8], second[7:0]}
    localparam logic [23:0] VEC [8] = '{
        {2'd3, 1'b0, 1'b0, 3'd1, 1'b0, 8'hA5, 8'h3C},
        {2'd0, 1'b1, 1'b0, 3'd0, 1'b0, 8'hE6, 8'h1F},
        {2'd2, 1'b1, 1'b1, 3'd2, 1'b0, 8'h5A, 8'h81},
        {2'd1, 1'b1, 1'b0, 3'd3, 1'b0, 8'h2D, 8'h12},
        {2'd3, 1'b1, 1'b1, 3'd4, 1'b0, 8'h00, 8'hFF},
        {2'd3, 1'b1, 1'b0, 3'd5, 1'b0, 8'h96, 8'h69},
        {2'd0, 1'b0, 1'b0, 3'd7, 1'b0, 8'h15, 8'h0A},
        {2'd3, 1'b0, 1'b0, 3'd0, 1'b0, 8'h01, 8'h80}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int stop_ticks(input logic [2:0] code);
        case (code)
            3'd0: return 0;
            3'd1: return 16;
            3'd2: return 24;
            3'd3: return 32;
            3'd4: return 40;
            default: return 48;
        endcase
    endfunction

    function automatic int frame_ticks();
        return 16 * (1 + 5 + int'(cfg_len) + int'(cfg_par_en)) + stop_ticks(cfg_stop);
    endfunction

    task automatic wait_cnt(input int target);
        while (tcount < target) @(negedge clk);
    endtask

    task automatic push(input logic [7:0] d);
        int guard = 0;
        while (!in_ready && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        in_valid = 1'b1;
        in_data  = d;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R6 in_ready low after accept", in_ready, 0);
        chk("R7 tx_empty low while held", tx_empty, 0);
    endtask

    task automatic wait_fall(output int base);
        int guard = 0;
        while (txd !== 1'b0 && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        chk("R2 start bit seen", txd, 0);
        base = tcount;
    endtask

    task automatic check_frame(input int base, input logic [7:0] d);
        int nb = 5 + int'(cfg_len);
        int st = stop_ticks(cfg_stop);
        logic p = cfg_par_odd;
        wait_cnt(base + 8);
        chk("R2 start bit low", txd, 0);
        for (int i = 0; i < nb; i++) begin
            p = p ^ d[i];
            wait_cnt(base + 16 * (i + 1) + 8);
            chk("R2 data bit", txd, d[i]);
        end
        if (cfg_par_en) begin
            wait_cnt(base + 16 * (nb + 1) + 8);
            chk("R3 parity bit", txd, p);
        end
        if (st > 0) begin
            wait_cnt(base + 16 * (1 + nb + int'(cfg_par_en)) + st - 1);
            chk("R4 stop interval high", txd, 1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired R1 actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int base;
        int n;
        repeat (4) @(negedge clk);
        chk("R1 reset txd", txd, 1);
        chk("R1 reset in_ready", in_ready, 1);
        chk("R1 reset tx_empty", tx_empty, 1);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk("R1 idle txd with ticks", txd, 1);

        // Table of formats: two characters back to back each
        for (int v = 0; v < 8; v++) begin
            cfg_len     = VEC[v][23:22];
            cfg_par_en  = VEC[v][21];
            cfg_par_odd = VEC[v][20];
            cfg_stop    = VEC[v][19:17];
            n = frame_ticks();
            push(VEC[v][15:8]);
            wait_fall(base);
            chk("R7 tx_empty set as start begins", tx_empty, 1);
            push(VEC[v][7:0]);
            check_frame(base, VEC[v][15:8]);
            // R4 / R5: the second start lands exactly one frame later
            check_frame(base + n, VEC[v][7:0]);
            wait_cnt(base + 2 * n + 8);
            chk("R1 idle after frames txd", txd, 1);
            chk("R1 idle after frames tx_empty", tx_empty, 1);
            chk("R6 idle in_ready", in_ready, 1);
        end

        // Break in the middle of a frame, with a character waiting
        cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_par_odd = 1'b0; cfg_stop = 3'd1;
        push(8'hC3);
        wait_fall(base);
        wait_cnt(base + 40);
        brk = 1'b1;
        @(negedge clk);
        chk("R8 break forces low", txd, 0);
        push(8'h5E);
        wait_cnt(tcount + 40);
        chk("R8 line low during break", txd, 0);
        chk("R8 held char kept", tx_empty, 0);
        brk = 1'b0;
        @(negedge clk);
        base = tcount;
        chk("R9 high after release", txd, 1);
        wait_cnt(base + 15);
        chk("R9 high for a bit time", txd, 1);
        check_frame(base + 16, 8'h5E);

        // Break from idle
        wait_cnt(tcount + 40);
        brk = 1'b1;
        @(negedge clk);
        chk("R8 break from idle", txd, 0);
        brk = 1'b0;
        @(negedge clk);
        chk("R9 release from idle", txd, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule